// File: doc/BRIEF.md
# Four-Channel Block Transfer Engine

This block holds four independent transfer channels that copy blocks of 16-bit or 32-bit units from one address range to another through a single memory master port. Each channel is set up through a small write port: a source address, a destination address, a unit count and a control word. Setting the control word's enable bit arms the channel. The channel then starts at once, or on every horizontal-blank or vertical-blank pulse, according to its start field.

Every unit is moved as a read on the master port followed by a write of the same data. Each channel's source and destination pointers step up, step down or hold, independently of each other. At the end of a block a channel can pulse its own interrupt line. It then either disarms itself or, in repeat mode, reloads its count and waits for its next start. When several channels want the port, they are served one whole block at a time, and the lowest channel number goes first.

Top module: `dmac4_top`

## Requirements
- R1: After reset every channel's control readback is zero, `m_req` is low and every `irq` line is low.
- R2: Setup select codes are 0 source, 1 destination, 2 count and 3 control. The control bits are: bit 0 enable, bit 1 32-bit units, bits [3:2] start mode, bits [5:4] source step, bits [7:6] destination step, bit 8 repeat and bit 9 interrupt enable. `rd_ctl` returns the control word last written, except where R8 changes it.
- R3: Address writes clear bit 0. For a 32-bit block, bits [1:0] of both working pointers are cleared when the block starts, so every master address is aligned to the unit size.
- R4: A count of 0 means `LONG_BLK` units (default 0x10000) on the highest channel and `SHORT_BLK` units (default 0x4000) on every other channel. Any other count moves exactly that many units.
- R5: Step codes are 0 up, 1 down, 2 hold and 3 up-with-reload. A step is 2 bytes for 16-bit units and 4 bytes for 32-bit units.
- R6: Working source, destination and count are copied from the setup registers only when enable goes from 0 to 1. Rewriting an address while the channel is enabled does not affect the blocks that follow.
- R7: Start code 0 starts as soon as the channel is enabled. Code 1 starts on each `hblank` pulse and code 2 on each `vblank` pulse while the channel is enabled. Code 3 never starts a block, and pulses of the other kind are ignored.
- R8: When a block without repeat ends, bit 0 of the control readback clears and all other bits keep their values.
- R9: In repeat mode the channel stays enabled and the count reloads. The destination reloads from its register only with step code 3. Otherwise both pointers carry on from where the block ended.
- R10: With bit 9 set, a channel's `irq` line is high for exactly one cycle, the cycle after its last write is accepted. With bit 9 clear, the line stays low.
- R11: Blocks are never interleaved. When several channels are waiting, the lowest channel number is served first.
- R12: Each unit is a read (`m_we`=0) followed by a write (`m_we`=1) of the data that was read. The port holds its request, address and direction until `m_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Setup write strobe |
| cfg_ch | input | 2 | Channel addressed by the setup write |
| cfg_sel | input | 2 | Setup register select |
| cfg_wdata | input | 32 | Setup write data |
| rd_ch | input | 2 | Channel whose control word is read back |
| rd_ctl | output | 16 | Control word readback |
| hblank | input | 1 | Horizontal-blank start pulse |
| vblank | input | 1 | Vertical-blank start pulse |
| irq | output | 4 | Per-channel completion pulse |
| m_req | output | 1 | Master port request |
| m_we | output | 1 | Master port write (1) or read (0) |
| m_wide | output | 1 | Master port unit size, 1 = 32-bit |
| m_addr | output | 32 | Master port byte address |
| m_wdata | output | 32 | Master port write data |
| m_rdata | input | 32 | Master port read data |
| m_ready | input | 1 | Master port phase accepted |

## Verification
Two starts can reach the arbiter in the same cycle: the start of a blank-timed channel and the immediate start of a channel that is being enabled. The bench provokes this by raising `hblank` on the same clock edge on which it writes the enable of an immediate channel with a lower number. The master-port log must then show the whole block of the lower channel before any access of the higher one. A second case has a blank pulse land on a repeat channel while it is idle after completion. This is judged by where the next block's pointers resume.

// File: rtl/dmac4_pkg.sv
package dmac4_pkg;
  typedef enum logic [1:0] {T_NOW = 2'd0, T_HBL = 2'd1, T_VBL = 2'd2, T_SPC = 2'd3} tim_e;
  typedef enum logic [1:0] {S_UP = 2'd0, S_DOWN = 2'd1, S_HOLD = 2'd2, S_UPRL = 2'd3} stp_e;
  typedef enum logic [1:0] {CF_SRC = 2'd0, CF_DST = 2'd1, CF_CNT = 2'd2, CF_CTL = 2'd3} cfg_e;

  localparam int B_EN   = 0;
  localparam int B_WIDE = 1;
  localparam int B_TIM  = 2;
  localparam int B_SC   = 4;
  localparam int B_DC   = 6;
  localparam int B_RPT  = 8;
  localparam int B_IRQ  = 9;

  // signed pointer increment for one unit
  function automatic logic [31:0] step_of(input logic [1:0] code, input logic wide);
    logic [31:0] sz;
    sz = wide ? 32'd4 : 32'd2;
    case (code)
      S_DOWN:  return -sz;
      S_HOLD:  return 32'd0;
      default: return sz;
    endcase
  endfunction

  // pointer alignment applied at block start
  function automatic logic [31:0] align_of(input logic [31:0] a, input logic wide);
    return wide ? {a[31:2], 2'b00} : {a[31:1], 1'b0};
  endfunction
endpackage

// File: rtl/dmac4_chan.sv
module dmac4_chan
  import dmac4_pkg::*;
#(
  parameter int IDX       = 0,
  parameter int NCH       = 4,
  parameter int CNT_W     = 16,
  parameter int LONG_BLK  = 65536,
  parameter int SHORT_BLK = 16384,
  localparam int CW       = CNT_W + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [31:0]   cfg_wdata,
  input  logic          hbl,
  input  logic          vbl,
  input  logic          grant,
  input  logic          done,
  input  logic [31:0]   end_src,
  input  logic [31:0]   end_dst,
  output logic          req_o,
  output logic [15:0]   ctl_o,
  output logic [31:0]   src_o,
  output logic [31:0]   dst_o,
  output logic [CW-1:0] cnt_o,
  output logic          irq_o
);
  logic [31:0]      src_r, dst_r, wsrc, wdst;
  logic [CNT_W-1:0] cnt_r;
  logic [CW-1:0]    wcnt;
  logic [15:0]      ctl;
  logic             pend, irq_q;

  function automatic logic [CW-1:0] units_of(input logic [CNT_W-1:0] c);
    if (c != '0) return CW'(c);
    return (IDX == NCH - 1) ? CW'(LONG_BLK) : CW'(SHORT_BLK);
  endfunction

  wire [1:0] tim       = ctl[B_TIM +: 2];
  wire       en        = ctl[B_EN];
  wire       ctl_wr    = cfg_we && (cfg_sel == CF_CTL);
  wire       arm       = ctl_wr && !en && cfg_wdata[B_EN];
  wire       blank_hit = en && ((tim == T_HBL && hbl) || (tim == T_VBL && vbl));
  wire       re_now    = done && ctl[B_RPT] && (tim == T_NOW);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_r <= '0; dst_r <= '0; cnt_r <= '0; ctl <= '0;
      wsrc  <= '0; wdst  <= '0; wcnt  <= '0;
      pend  <= 1'b0; irq_q <= 1'b0;
    end else begin
      irq_q <= done && ctl[B_IRQ];
      if (grant) pend <= 1'b0;
      if (done) begin
        wsrc <= end_src;
        if (ctl[B_RPT]) begin
          wcnt <= units_of(cnt_r);
          wdst <= (ctl[B_DC +: 2] == S_UPRL) ? dst_r : end_dst;
        end else begin
          wdst       <= end_dst;
          ctl[B_EN]  <= 1'b0;
        end
      end
      if (blank_hit || re_now) pend <= 1'b1;
      if (cfg_we) begin
        case (cfg_sel)
          CF_SRC: src_r <= {cfg_wdata[31:1], 1'b0};
          CF_DST: dst_r <= {cfg_wdata[31:1], 1'b0};
          CF_CNT: cnt_r <= cfg_wdata[CNT_W-1:0];
          default: begin
            ctl <= cfg_wdata[15:0];
            if (arm) begin
              wsrc <= src_r;
              wdst <= dst_r;
              wcnt <= units_of(cnt_r);
              pend <= (cfg_wdata[B_TIM +: 2] == T_NOW);
            end
            if (!cfg_wdata[B_EN]) pend <= 1'b0;
          end
        endcase
      end
    end
  end

  assign req_o = pend && en;
  assign ctl_o = ctl;
  assign src_o = wsrc;
  assign dst_o = wdst;
  assign cnt_o = wcnt;
  assign irq_o = irq_q;
endmodule

// File: rtl/dmac4_prio.sv
module dmac4_prio #(
  parameter int NCH = 4,
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [NCH-1:0] req,
  output logic [NCH-1:0] pick,
  output logic [IW-1:0]  idx,
  output logic           any
);
  always_comb begin
    pick = '0;
    idx  = '0;
    any  = 1'b0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (req[i]) begin
        pick    = '0;
        pick[i] = 1'b1;
        idx     = IW'(i);
        any     = 1'b1;
      end
    end
  end
endmodule

// File: rtl/dmac4_mover.sv
module dmac4_mover
  import dmac4_pkg::*;
#(
  parameter int NCH = 4,
  parameter int CW  = 17
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           any,
  input  logic [NCH-1:0] pick,
  input  logic [31:0]    ld_src,
  input  logic [31:0]    ld_dst,
  input  logic [CW-1:0]  ld_cnt,
  input  logic           ld_wide,
  input  logic [1:0]     ld_sc,
  input  logic [1:0]     ld_dc,
  output logic [NCH-1:0] grant,
  output logic [NCH-1:0] done,
  output logic [31:0]    end_src,
  output logic [31:0]    end_dst,
  output logic           m_req,
  output logic           m_we,
  output logic           m_wide,
  output logic [31:0]    m_addr,
  output logic [31:0]    m_wdata,
  input  logic [31:0]    m_rdata,
  input  logic           m_ready
);
  typedef enum logic [1:0] {M_IDLE, M_RD, M_WR} mst_e;

  mst_e           st;
  logic [31:0]    a_s, a_d, hold_q;
  logic [CW-1:0]  left;
  logic           wide;
  logic [1:0]     sc, dc;
  logic [NCH-1:0] own;

  wire idle     = (st == M_IDLE);
  wire unit_end = (st == M_WR) && m_ready;
  wire last     = unit_end && (left == CW'(1));

  assign grant   = idle ? pick : '0;
  assign done    = last ? own : '0;
  assign end_src = a_s + step_of(sc, wide);
  assign end_dst = a_d + step_of(dc, wide);
  assign m_req   = !idle;
  assign m_we    = (st == M_WR);
  assign m_wide  = wide;
  assign m_addr  = (st == M_WR) ? a_d : a_s;
  assign m_wdata = hold_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= M_IDLE; a_s <= '0; a_d <= '0; hold_q <= '0; left <= '0;
      wide <= 1'b0; sc <= '0; dc <= '0; own <= '0;
    end else begin
      case (st)
        M_IDLE: if (any) begin
          a_s  <= align_of(ld_src, ld_wide);
          a_d  <= align_of(ld_dst, ld_wide);
          left <= ld_cnt;
          wide <= ld_wide;
          sc   <= ld_sc;
          dc   <= ld_dc;
          own  <= pick;
          st   <= M_RD;
        end
        M_RD: if (m_ready) begin
          hold_q <= m_rdata;
          st     <= M_WR;
        end
        default: if (m_ready) begin
          a_s  <= end_src;
          a_d  <= end_dst;
          left <= left - CW'(1);
          st   <= last ? M_IDLE : M_RD;
        end
      endcase
    end
  end
endmodule

// File: rtl/dmac4_top.sv
module dmac4_top
  import dmac4_pkg::*;
#(
  parameter int NCH       = 4,
  parameter int CNT_W     = 16,
  parameter int LONG_BLK  = 65536,
  parameter int SHORT_BLK = 16384,
  localparam int IW       = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int CW       = CNT_W + 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic [IW-1:0]  cfg_ch,
  input  logic [1:0]     cfg_sel,
  input  logic [31:0]    cfg_wdata,
  input  logic [IW-1:0]  rd_ch,
  output logic [15:0]    rd_ctl,
  input  logic           hblank,
  input  logic           vblank,
  output logic [NCH-1:0] irq,
  output logic           m_req,
  output logic           m_we,
  output logic           m_wide,
  output logic [31:0]    m_addr,
  output logic [31:0]    m_wdata,
  input  logic [31:0]    m_rdata,
  input  logic           m_ready
);
  logic [31:0]    c_src [NCH];
  logic [31:0]    c_dst [NCH];
  logic [CW-1:0]  c_cnt [NCH];
  logic [15:0]    c_ctl [NCH];
  logic [NCH-1:0] ch_req, ch_pick, ch_grant, ch_done;
  logic [IW-1:0]  sel_idx;
  logic           sel_any;
  logic [31:0]    end_src, end_dst;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    dmac4_chan #(
      .IDX(g), .NCH(NCH), .CNT_W(CNT_W), .LONG_BLK(LONG_BLK), .SHORT_BLK(SHORT_BLK)
    ) u_ch (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we && (cfg_ch == IW'(g))), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
      .hbl(hblank), .vbl(vblank),
      .grant(ch_grant[g]), .done(ch_done[g]), .end_src(end_src), .end_dst(end_dst),
      .req_o(ch_req[g]), .ctl_o(c_ctl[g]), .src_o(c_src[g]), .dst_o(c_dst[g]),
      .cnt_o(c_cnt[g]), .irq_o(irq[g])
    );
  end

  dmac4_prio #(.NCH(NCH)) u_prio (
    .req(ch_req), .pick(ch_pick), .idx(sel_idx), .any(sel_any)
  );

  dmac4_mover #(.NCH(NCH), .CW(CW)) u_mv (
    .clk(clk), .rst_n(rst_n), .any(sel_any), .pick(ch_pick),
    .ld_src(c_src[sel_idx]), .ld_dst(c_dst[sel_idx]), .ld_cnt(c_cnt[sel_idx]),
    .ld_wide(c_ctl[sel_idx][B_WIDE]), .ld_sc(c_ctl[sel_idx][B_SC +: 2]),
    .ld_dc(c_ctl[sel_idx][B_DC +: 2]),
    .grant(ch_grant), .done(ch_done), .end_src(end_src), .end_dst(end_dst),
    .m_req(m_req), .m_we(m_we), .m_wide(m_wide), .m_addr(m_addr),
    .m_wdata(m_wdata), .m_rdata(m_rdata), .m_ready(m_ready)
  );

  assign rd_ctl = c_ctl[rd_ch];
endmodule

// File: rtl/dmac4_chk.sv
module dmac4_chk #(
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] req,
  input logic [NCH-1:0] grant,
  input logic [NCH-1:0] done,
  input logic [NCH-1:0] irq,
  input logic           m_req,
  input logic           m_we,
  input logic           m_wide,
  input logic [31:0]    m_addr,
  input logic           m_ready
);
  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)); // R11
  AST_GRANT_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    (grant != '0) |-> ((req & (grant - 1'b1)) == '0)); // R11
  AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (m_req && !m_ready) |=> (m_req && $stable(m_addr) && $stable(m_we))); // R12
  AST_READ_THEN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (m_req && !m_we && m_ready) |=> (m_req && m_we)); // R12
  AST_WIDE_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (m_req && m_wide) |-> (m_addr[1:0] == 2'b00)); // R3
  AST_HALF_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    m_req |-> !m_addr[0]); // R3
  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (irq & $past(irq)) == '0); // R10
  AST_IRQ_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (irq & ~$past(done)) == '0); // R10
endmodule

bind dmac4_top dmac4_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .req(ch_req), .grant(ch_grant), .done(ch_done),
  .irq(irq), .m_req(m_req), .m_we(m_we), .m_wide(m_wide), .m_addr(m_addr),
  .m_ready(m_ready)
);

// File: tb/sim_dmac4_top.sv
module sim_dmac4_top;
  localparam int LONG_T  = 32;
  localparam int SHORT_T = 8;

  typedef struct packed {
    logic [1:0]  ch;
    logic        wide;
    logic [1:0]  sc;
    logic [1:0]  dc;
    logic        irqe;
    logic [31:0] src;
    logic [31:0] dst;
    logic [15:0] cnt;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{2'd0, 1'b0, 2'd0, 2'd0, 1'b1, 32'h0000_1001, 32'h0000_2000, 16'd4},
    '{2'd1, 1'b1, 2'd1, 2'd2, 1'b0, 32'h0000_3006, 32'h0000_4002, 16'd3},
    '{2'd2, 1'b1, 2'd2, 2'd3, 1'b1, 32'h0000_5000, 32'h0000_6000, 16'd5},
    '{2'd3, 1'b0, 2'd0, 2'd1, 1'b1, 32'h0000_7000, 32'h0000_8010, 16'd0},
    '{2'd0, 1'b1, 2'd0, 2'd0, 1'b0, 32'h0000_9000, 32'h0000_A000, 16'd0},
    '{2'd2, 1'b0, 2'd1, 2'd0, 1'b1, 32'h0000_B100, 32'h0000_C000, 16'd0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_ch = '0;
  logic [1:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic [1:0]  rd_ch = '0;
  logic [15:0] rd_ctl;
  logic        hblank = 1'b0, vblank = 1'b0;
  logic [3:0]  irq;
  logic        m_req, m_we, m_wide, m_ready;
  logic [31:0] m_addr, m_wdata, m_rdata;
  logic        stall = 1'b0;
  int          cyc = 0;

  dmac4_top #(.NCH(4), .CNT_W(16), .LONG_BLK(LONG_T), .SHORT_BLK(SHORT_T)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .rd_ch(rd_ch), .rd_ctl(rd_ctl), .hblank(hblank),
    .vblank(vblank), .irq(irq), .m_req(m_req), .m_we(m_we), .m_wide(m_wide),
    .m_addr(m_addr), .m_wdata(m_wdata), .m_rdata(m_rdata), .m_ready(m_ready)
  );

  function automatic logic [31:0] mem_of(input logic [31:0] a);
    return {a[15:0], ~a[15:0]};
  endfunction

  assign m_rdata = mem_of(m_addr);
  always @(posedge clk) cyc <= cyc + 1;
  assign m_ready = !stall || (cyc % 3 == 0);

  logic [31:0] la [0:511];
  logic        lw [0:511];
  logic [31:0] ld [0:511];
  int          ln = 0;
  int          irqn [4] = '{0, 0, 0, 0};
  int          errors = 0, checks = 0;

  always @(negedge clk) begin
    if (rst_n && m_req && m_ready && ln < 512) begin
      la[ln] = m_addr; lw[ln] = m_we; ld[ln] = m_wdata; ln++;
    end
    for (int i = 0; i < 4; i++) if (rst_n && irq[i]) irqn[i]++;
  end

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic clr_log();
    ln = 0;
    for (int i = 0; i < 4; i++) irqn[i] = 0;
  endtask

  task automatic wr(input int ch, input logic [1:0] sel, input logic [31:0] d);
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_ch = 2'(ch); cfg_sel = sel; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic pulse(input bit vb);
    @(posedge clk); #1;
    if (vb) vblank = 1'b1; else hblank = 1'b1;
    @(posedge clk); #1;
    hblank = 1'b0; vblank = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic read_ctl(input int ch, output logic [15:0] v);
    @(negedge clk); rd_ch = 2'(ch); #1; v = rd_ctl;
  endtask

  task automatic wait_off(input int ch);
    for (int t = 0; t < 4000; t++) begin
      @(negedge clk); rd_ch = 2'(ch); #1;
      if (!rd_ctl[0]) break;
    end
    idle(3);
  endtask

  function automatic int step_b(input logic [1:0] code, input logic wide);
    int sz;
    sz = wide ? 4 : 2;
    if (code == 2'd1) return -sz;
    if (code == 2'd2) return 0;
    return sz;
  endfunction

  task automatic chk_blk(input int at, input int n, input logic [31:0] s, input logic [31:0] d,
                         input logic [1:0] sc, input logic [1:0] dc, input logic wide,
                         input string tag);
    logic [31:0] ra, wa, fa_act, fa_exp, sb, db;
    int bad_a, bad_d;
    bad_a = 0; bad_d = 0; fa_act = '0; fa_exp = '0;
    sb = wide ? (s & ~32'h3) : (s & ~32'h1);
    db = wide ? (d & ~32'h3) : (d & ~32'h1);
    for (int k = 0; k < n; k++) begin
      ra = sb + 32'(k * step_b(sc, wide));
      wa = db + 32'(k * step_b(dc, wide));
      if (la[at+2*k] !== ra || lw[at+2*k] !== 1'b0 ||
          la[at+2*k+1] !== wa || lw[at+2*k+1] !== 1'b1) begin
        if (bad_a == 0) begin
          fa_act = (la[at+2*k] !== ra) ? la[at+2*k] : la[at+2*k+1];
          fa_exp = (la[at+2*k] !== ra) ? ra : wa;
        end
        bad_a++;
      end
      if (ld[at+2*k+1] !== mem_of(ra)) bad_d++;
    end
    chk(bad_a == 0, tag, "unit addresses", fa_act, fa_exp);
    chk(bad_d == 0, "R12", "write data equals read data", bad_d, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R12 watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] v, cw;
    int n;
    // R1 reset state
    idle(2);
    chk(m_req === 1'b0, "R1", "m_req in reset", m_req, 0);
    rst_n = 1'b1;
    idle(2);
    for (int c = 0; c < 4; c++) begin
      read_ctl(c, v);
      chk(v === 16'h0, "R1", "control readback after reset", v, 0);
    end
    chk(irq === 4'h0 && m_req === 1'b0, "R1", "irq and m_req after reset", {irq, m_req}, 0);

    // vector table: immediate blocks
    for (int i = 0; i < 6; i++) begin
      clr_log();
      stall = (i % 2 == 1);
      cw = 16'((int'(VEC[i].irqe) << 9) | (int'(VEC[i].dc) << 6) |
               (int'(VEC[i].sc) << 4) | (int'(VEC[i].wide) << 1) | 1);
      wr(VEC[i].ch, 2'd0, VEC[i].src);
      wr(VEC[i].ch, 2'd1, VEC[i].dst);
      wr(VEC[i].ch, 2'd2, {16'h0, VEC[i].cnt});
      wr(VEC[i].ch, 2'd3, {16'h0, cw});
      wait_off(VEC[i].ch);
      n = (VEC[i].cnt != 0) ? int'(VEC[i].cnt) : ((VEC[i].ch == 2'd3) ? LONG_T : SHORT_T);
      chk(ln == 2 * n, "R4", "accesses in block", ln, 2 * n);
      chk_blk(0, n, VEC[i].src, VEC[i].dst, VEC[i].sc, VEC[i].dc, VEC[i].wide, "R5 R3");
      read_ctl(VEC[i].ch, v);
      chk(v === (cw & 16'hFFFE), "R8", "enable cleared, other bits kept", v, cw & 16'hFFFE);
      chk(irqn[VEC[i].ch] == int'(VEC[i].irqe), "R10", "irq pulse cycles",
          irqn[VEC[i].ch], VEC[i].irqe);
    end
    stall = 1'b0;

    // R7: special start code never starts, channel 0
    clr_log();
    wr(0, 2'd0, 32'h100); wr(0, 2'd1, 32'h200); wr(0, 2'd2, 32'd2);
    wr(0, 2'd3, 32'h000D);
    pulse(0); pulse(1); idle(20);
    chk(ln == 0, "R7", "special start code moved data", ln, 0);
    read_ctl(0, v);
    chk(v === 16'h000D, "R2", "control readback while armed", v, 16'h000D);
    wr(0, 2'd3, 32'h0);

    // R7/R9/R6: hblank-timed repeat with destination reload
    clr_log();
    wr(1, 2'd0, 32'h100); wr(1, 2'd1, 32'h200); wr(1, 2'd2, 32'd2);
    wr(1, 2'd3, 32'h03C5);
    idle(10);
    chk(ln == 0, "R7", "hblank channel started without pulse", ln, 0);
    pulse(1); idle(10);
    chk(ln == 0, "R7", "hblank channel started on vblank", ln, 0);
    pulse(0); idle(20);
    chk(ln == 4, "R7", "accesses after hblank", ln, 4);
    chk_blk(0, 2, 32'h100, 32'h200, 2'd0, 2'd3, 1'b0, "R7");
    read_ctl(1, v);
    chk(v[0] === 1'b1, "R9", "repeat channel stays enabled", v[0], 1);
    chk(irqn[1] == 1, "R10", "irq after repeat block", irqn[1], 1);
    wr(1, 2'd0, 32'h900);
    pulse(0); idle(20);
    chk(ln == 8, "R9", "count reloaded", ln, 8);
    chk_blk(4, 2, 32'h104, 32'h200, 2'd0, 2'd3, 1'b0, "R6 R9");
    wr(1, 2'd3, 32'h0);

    // R9: vblank repeat, destination carries on
    clr_log();
    wr(2, 2'd0, 32'h400); wr(2, 2'd1, 32'h500); wr(2, 2'd2, 32'd1);
    wr(2, 2'd3, 32'h0129);
    pulse(1); idle(10); pulse(1); idle(10);
    chk(ln == 4, "R9", "two vblank blocks", ln, 4);
    chk(la[1] === 32'h500 && la[3] === 32'h502, "R9", "destination carries on",
        {la[1], la[3]}, {32'h500, 32'h502});
    chk(la[0] === 32'h400 && la[2] === 32'h400, "R5", "held source", la[2], 32'h400);
    wr(2, 2'd3, 32'h0);

    // R11: blank start and immediate start land in the same cycle
    clr_log();
    wr(3, 2'd0, 32'hD000); wr(3, 2'd1, 32'hE000); wr(3, 2'd2, 32'd2);
    wr(3, 2'd3, 32'h0005);
    wr(1, 2'd0, 32'hD100); wr(1, 2'd1, 32'hE100); wr(1, 2'd2, 32'd2);
    @(posedge clk); #1;
    hblank = 1'b1; cfg_we = 1'b1; cfg_ch = 2'd1; cfg_sel = 2'd3; cfg_wdata = 32'h1;
    @(posedge clk); #1;
    hblank = 1'b0; cfg_we = 1'b0;
    wait_off(3);
    chk(ln == 8, "R11", "both blocks ran", ln, 8);
    chk_blk(0, 2, 32'hD100, 32'hE100, 2'd0, 2'd0, 1'b0, "R11");
    chk_blk(4, 2, 32'hD000, 32'hE000, 2'd0, 2'd0, 1'b0, "R11");
    chk(irqn[1] == 0 && irqn[3] == 0, "R10", "no irq when disabled", irqn[3], 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule